// File: doc/BRIEF.md
# Packet History Sequencer with Round-Robin Dispatch

This block sits in front of a group of processing cores that each keep a private replica of some shared per-flow state. Packets enter one at a time on a streaming input with a valid/ready handshake. Each packet is represented by one header word. The block handles packets in a single global arrival order. It hands every packet on unchanged and tags it with a destination core index. The index is chosen round-robin over `N_CORES` cores, so each core receives every `N_CORES`-th packet.

A key field is taken from each packet header at a fixed bit offset. Only this key field is kept, never the whole packet. It is stored in a small ring buffer that holds the keys of the last `N_CORES-1` packets. Every outgoing packet carries a trailer of those earlier keys, oldest first, with one valid bit per entry. The packet's own key and a wrapping sequence number are also attached. A core replays the trailer keys first, in order, to bring its state replica up to date with the packets that went to the other cores. It then processes its own packet. The ring read and the write of the current key happen in the same cycle, so back-to-back packets always see complete history.

The output is a single register stage. When the consumer deasserts ready, the held output stays frozen and the input is stalled. No packet is dropped or reordered. `N_CORES` must be at least 2.

Top module: `phs_history_seq`

## Requirements
- R1: Every accepted input word appears exactly once on `out_word`, unchanged, in arrival order. It becomes valid on the clock edge that accepts it.
- R2: `out_core` is 0 for the first packet after reset. It then increases by one per packet and wraps from `N_CORES-1` to 0, so packet number n (counting from 0 after reset) goes to core n mod `N_CORES`.
- R3: `out_key` equals bits `[KEY_LSB +: KEY_W]` of the packet's own input word.
- R4: For packet n, history slot i (bits `[i*KEY_W +: KEY_W]` of `out_hist`, with i from 0 to `N_CORES-2`) holds the key of packet n-(`N_CORES`-1)+i. Slot 0 is the oldest, and the highest slot is the packet just before.
- R5: Bit i of `out_hist_vld` is 1 exactly when packet n-(`N_CORES`-1)+i exists since reset. As a result, the first `N_CORES-1` packets carry partial histories, with the invalid slots at the low (oldest) end.
- R6: When `out_ready` stays high, `in_ready` stays high, so one packet is accepted every cycle. Each packet in such a burst carries fully updated history.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values until the transfer.
- R8: `out_seq` is 0 for the first packet after reset. It increases by one per packet and wraps modulo 2^`SEQ_W`.
- R9: The core index, the sequence number and the ring pointer advance only when an input packet is accepted. Idle and stalled cycles leave them unchanged.
- R10: Reset clears `out_valid`, clears every history valid bit, and restarts the core index and the sequence number at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet word is present |
| in_ready | output | 1 | Block can accept the input word this cycle |
| in_word | input | PKT_W | Packet header word |
| out_valid | output | 1 | Output packet is present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_word | output | PKT_W | Packet header word, unchanged |
| out_core | output | $clog2(N_CORES) | Destination core index |
| out_key | output | KEY_W | Key field of this packet |
| out_hist | output | (N_CORES-1)*KEY_W | Keys of the preceding packets, oldest in slot 0 |
| out_hist_vld | output | N_CORES-1 | Per-slot history valid bits |
| out_seq | output | SEQ_W | Per-packet sequence number |

## Verification
A pointer that slips or advances on a stalled cycle shows up as a wrong history slot on the very next packet. It also reaches the core index within one rotation. The bench predicts every field of every output from its own count of accepted packets and compares them all at each transfer, so such a slip is caught on the first affected packet. The tests cover back-to-back bursts, irregular consumer stalls, input gaps, a run past the sequence wrap, and a reset after traffic. Together these exercise every path that moves the counters.

// File: rtl/phs_pkg.sv
package phs_pkg;

  // Increment with wrap at lim (v assumed below lim).
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v + 32'd1 >= lim) ? 32'd0 : v + 32'd1;
  endfunction

  // Ring slot that lies off entries past ptr, in a ring of depth entries.
  function automatic logic [31:0] ring_slot(input logic [31:0] ptr, input logic [31:0] off,
                                            input logic [31:0] depth);
    logic [31:0] s;
    s = ptr + off;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/phs_hist_ring.sv
module phs_hist_ring #(
  parameter int KEY_W = 32,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [KEY_W-1:0]   wr_key,
  output logic [DEPTH*KEY_W-1:0] rd_keys,
  output logic [DEPTH-1:0]   rd_vld
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KEY_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] wp_q;

  // Slot at the write pointer is the oldest entry; read oldest first.
  for (genvar i = 0; i < DEPTH; i++) begin : g_rd
    logic [31:0] slot;
    assign slot = phs_pkg::ring_slot(32'(wp_q), 32'(i), 32'(DEPTH));
    assign rd_keys[i*KEY_W +: KEY_W] = mem_q[slot[PTR_W-1:0]];
    assign rd_vld[i] = vld_q[slot[PTR_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      vld_q <= '0;
      wp_q  <= '0;
    end else if (wr_en) begin
      mem_q[wp_q] <= wr_key;
      vld_q[wp_q] <= 1'b1;
      wp_q        <= PTR_W'(phs_pkg::wrap_inc(32'(wp_q), 32'(DEPTH)));
    end
  end

  // R9: pointer moves only on a write
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wp_q) && $stable(vld_q));

  // R5: while filling, each write adds exactly one valid entry
  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&vld_q)) |=> $countones(vld_q) == $past($countones(vld_q)) + 1);

endmodule

// File: rtl/phs_rr_tag.sv
module phs_rr_tag #(
  parameter int N_CORES = 4,
  parameter int SEQ_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  output logic [$clog2(N_CORES)-1:0] core_idx,
  output logic [SEQ_W-1:0]           seq
);
  localparam int CORE_W = $clog2(N_CORES);

  logic [CORE_W-1:0] core_q;
  logic [SEQ_W-1:0]  seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      seq_q  <= '0;
    end else if (adv) begin
      core_q <= CORE_W'(phs_pkg::wrap_inc(32'(core_q), 32'(N_CORES)));
      seq_q  <= seq_q + SEQ_W'(1);
    end
  end

  assign core_idx = core_q;
  assign seq      = seq_q;

  // R9: no advance without an accepted packet
  p_tag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(core_q) && $stable(seq_q));

  // R2: index never leaves the core range
  p_core_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(core_q) < N_CORES);

endmodule

// File: rtl/phs_history_seq.sv
module phs_history_seq #(
  parameter int N_CORES = 4,
  parameter int PKT_W   = 64,
  parameter int KEY_W   = 32,
  parameter int KEY_LSB = 16,
  parameter int SEQ_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [PKT_W-1:0]               in_word,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [PKT_W-1:0]               out_word,
  output logic [$clog2(N_CORES)-1:0]     out_core,
  output logic [KEY_W-1:0]               out_key,
  output logic [(N_CORES-1)*KEY_W-1:0]   out_hist,
  output logic [N_CORES-2:0]             out_hist_vld,
  output logic [SEQ_W-1:0]               out_seq
);
  localparam int HIST_D = N_CORES - 1;
  localparam int CORE_W = $clog2(N_CORES);

  // Named internal events
  logic                    accept;
  logic                    hold;
  logic [KEY_W-1:0]        key_now;
  logic [HIST_D*KEY_W-1:0] ring_keys;
  logic [HIST_D-1:0]       ring_vld;
  logic [CORE_W-1:0]       core_now;
  logic [SEQ_W-1:0]        seq_now;

  logic                    ov_q;
  logic [PKT_W-1:0]        word_q;
  logic [KEY_W-1:0]        key_q;
  logic [HIST_D*KEY_W-1:0] hist_q;
  logic [HIST_D-1:0]       hvld_q;
  logic [CORE_W-1:0]       core_q;
  logic [SEQ_W-1:0]        seq_q;

  assign hold     = ov_q && !out_ready;
  assign in_ready = !hold;
  assign accept   = in_valid && in_ready;
  assign key_now  = in_word[KEY_LSB +: KEY_W];

  phs_hist_ring #(.KEY_W(KEY_W), .DEPTH(HIST_D)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_key  (key_now),
    .rd_keys (ring_keys),
    .rd_vld  (ring_vld)
  );

  phs_rr_tag #(.N_CORES(N_CORES), .SEQ_W(SEQ_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (accept),
    .core_idx (core_now),
    .seq      (seq_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      word_q <= '0;
      key_q  <= '0;
      hist_q <= '0;
      hvld_q <= '0;
      core_q <= '0;
      seq_q  <= '0;
    end else if (accept) begin
      ov_q   <= 1'b1;
      word_q <= in_word;
      key_q  <= key_now;
      hist_q <= ring_keys;
      hvld_q <= ring_vld;
      core_q <= core_now;
      seq_q  <= seq_now;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid    = ov_q;
  assign out_word     = word_q;
  assign out_key      = key_q;
  assign out_hist     = hist_q;
  assign out_hist_vld = hvld_q;
  assign out_core     = core_q;
  assign out_seq      = seq_q;

  // R7: a refused output stays frozen
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready) |=> ov_q && $stable(word_q) && $stable(hist_q)
                             && $stable(core_q) && $stable(seq_q));

  // R4: newest history slot is the previous packet's key
  p_newest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ov_q) |=> hist_q[(HIST_D-1)*KEY_W +: KEY_W] == $past(key_q)
                         && hvld_q[HIST_D-1]);

  // R8: consecutive packets have consecutive sequence numbers
  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ov_q) |=> seq_q == SEQ_W'($past(seq_q) + SEQ_W'(1)));

  // R2: consecutive packets go to consecutive cores
  p_core_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ov_q) |=> 32'(core_q) == phs_pkg::wrap_inc(32'($past(core_q)), 32'(N_CORES)));

endmodule

// File: tb/tb_phs_history_seq.sv
`timescale 1ns/1ps
module tb_phs_history_seq;
  localparam int N   = 4;
  localparam int PW  = 64;
  localparam int KW  = 32;
  localparam int KL  = 16;
  localparam int SW  = 8;
  localparam int HD  = N - 1;
  localparam int CW  = $clog2(N);

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [PW-1:0] in_word = '0;
  logic out_valid;
  logic out_ready = 0;
  logic [PW-1:0] out_word;
  logic [CW-1:0] out_core;
  logic [KW-1:0] out_key;
  logic [HD*KW-1:0] out_hist;
  logic [HD-1:0] out_hist_vld;
  logic [SW-1:0] out_seq;

  int tests = 0;
  int fails = 0;
  int n_in = 0;
  int n_out = 0;
  int no_ready = 0;
  logic [PW-1:0] words [0:1023];

  always #4 clk = ~clk;

  phs_history_seq #(.N_CORES(N), .PKT_W(PW), .KEY_W(KW), .KEY_LSB(KL), .SEQ_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_core(out_core),
    .out_key(out_key), .out_hist(out_hist), .out_hist_vld(out_hist_vld), .out_seq(out_seq)
  );

  function automatic logic [PW-1:0] mk_word(input int n);
    logic [31:0] a;
    a = 32'(n) * 32'h9E3779B1 + 32'h1234;
    return {a ^ 32'hC3C30000, 32'(n) * 32'h01000193 + 32'h77};
  endfunction

  function automatic logic [KW-1:0] key_of(input logic [PW-1:0] w);
    return w[KL +: KW];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (packet %0d)", req, act, exp, n_out);
    end
  endtask

  task automatic check_out(input string tag);
    int n;
    logic [HD-1:0] ev;
    logic ok_h;
    n = n_out;
    chk(out_word == words[n], {"R1 word ", tag}, 128'(out_word), 128'(words[n]));
    chk(32'(out_core) == n % N, {"R2 core ", tag}, 128'(out_core), 128'(n % N));
    chk(out_key == key_of(words[n]), {"R3 key ", tag}, 128'(out_key), 128'(key_of(words[n])));
    chk(32'(out_seq) == n % (1 << SW), {"R8 seq ", tag}, 128'(out_seq), 128'(n % (1 << SW)));
    ok_h = 1'b1;
    for (int i = 0; i < HD; i++) begin
      int j;
      j = n - HD + i;
      ev[i] = (j >= 0);
      if (j >= 0 && out_hist[i*KW +: KW] != key_of(words[j])) ok_h = 1'b0;
    end
    chk(out_hist_vld == ev, {"R5 hist valid ", tag}, 128'(out_hist_vld), 128'(ev));
    chk(ok_h, {"R4 hist keys ", tag}, 128'(out_hist), 128'(0));
  endtask

  // rmode: 0 always ready, 1 ready two of three cycles, 2 alternate
  // gmode: 0 offer every cycle, 1 offer every fourth cycle
  task automatic run_traffic(input int npkts, input int rmode, input int gmode, input string tag);
    int sent;
    int target;
    int cyc;
    bit pend;
    bit stall_prev;
    logic [PW-1:0] held;
    sent = 0; cyc = 0; pend = 0; stall_prev = 0; held = '0; no_ready = 0;
    target = n_in + npkts;
    while (n_out < target && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (!pend) in_valid = 1'b0;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = cyc[0];
      endcase
      if (!pend && sent < npkts && (gmode == 0 || cyc % 4 == 0)) begin
        words[n_in] = mk_word(n_in);
        in_word  = words[n_in];
        in_valid = 1'b1;
        pend = 1'b1;
      end
      #1;
      if (stall_prev)
        chk(out_valid && out_word == held, {"R7 held output ", tag}, 128'(out_word), 128'(held));
      stall_prev = out_valid && !out_ready;
      if (stall_prev) begin
        chk(!in_ready, {"R7 input stalled ", tag}, 128'(in_ready), 128'(0));
        held = out_word;
      end
      if (in_valid && !in_ready) no_ready++;
      if (out_valid && out_ready) begin
        check_out(tag);
        n_out++;
      end
      if (in_valid && in_ready) begin
        n_in++;
        sent++;
        pend = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(n_out == target, {"R1 all delivered ", tag}, 128'(n_out), 128'(target));
  endtask

  task automatic do_reset();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_in = 0;
    n_out = 0;
    #1;
    chk(!out_valid, "R10 out_valid after reset", 128'(out_valid), 128'(0));
    chk(in_ready, "R10 in_ready after reset", 128'(in_ready), 128'(1));
  endtask

  task automatic t_reset();
    do_reset();
  endtask

  task automatic t_burst();
    run_traffic(9, 0, 0, "burst R6");
    chk(no_ready == 0, "R6 no stall in burst", 128'(no_ready), 128'(0));
  endtask

  task automatic t_stall();
    run_traffic(20, 1, 0, "stall R7");
  endtask

  task automatic t_gaps();
    run_traffic(15, 2, 1, "gaps R9");
  endtask

  task automatic t_wrap();
    run_traffic(270, 0, 0, "wrap R8");
  endtask

  task automatic t_reset_mid();
    run_traffic(5, 2, 0, "pre-reset R10");
    do_reset();
    run_traffic(4, 0, 0, "post-reset R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_burst();
    t_stall();
    t_gaps();
    t_wrap();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule